// File: doc/BRIEF.md
# Timeline Sync Object Table

This block keeps a table of timeline synchronization objects in on-chip storage. Each object is one sequence counter, selected by a handle. Command-stream clients use two operations. A wait asks whether an object has reached a target sequence. A signal stores a new sequence value into an object. Waits are cheap. Each wait is one table read with a one-cycle response. A client that wants to block simply issues the wait again until the response reports that the target is met. Waits leave no trace.

Every signal, whether it is applied or refused, produces a log record. The record carries the handle, the writing VMID and the value. A host-side reader drains these records through a valid/ready port. A host query port returns, for any handle, the current value and the VMID of the last writer that succeeded.

A mode register selects how signals are protected:

- **Fast mode** accepts every signal and relies only on the log.
- **Protected mode** checks a per-handle, per-VMID write-enable mask before applying a signal.

Top module: `syncobj_table`

## Requirements
- R1: After reset, every handle reads value 0 with writer VMID 0, the log is empty (`log_valid`=0), `log_overflow`=0, `sg_err`=0, and the block is in fast mode.
- R2: An accepted signal stores `sg_value` and `sg_vmid` for `sg_handle`. A query issued in any later cycle is answered one cycle after the request (`q_rsp_valid`=1), with `q_value` and `q_writer` holding that stored value and VMID.
- R3: A wait gets its response one cycle after the request (`wt_rsp_valid`=1). `wt_value` is the stored value. `wt_met`=1 exactly when the stored value is greater than or equal to `wt_target`, compared as unsigned numbers.
- R4: When a wait and a signal address the same handle in the same cycle, the wait response reports the value from before the write. A later wait sees the new value.
- R5: Waits and queries create no log record.
- R6: Every signal attempt pushes a log record {handle, VMID, value, rejected}, and records leave the log in arrival order. A record is removed in a cycle where `log_valid` and `log_ready` are both 1. It stays presented, unchanged, while `log_ready`=0.
- R7: In fast mode (`cfg_protect`=0 written through `cfg_we`), every signal is applied regardless of the permission masks, and `sg_err` stays 0.
- R8: In protected mode (`cfg_protect`=1), a signal whose VMID bit is clear in the handle's mask leaves the entry and its writer unchanged. It is still logged, with rejected=1, and it makes `sg_err` high for exactly the one cycle after the request.
- R9: `perm_we` replaces the mask of `perm_handle` with `perm_mask`, where bit i enables VMID i. In protected mode, a signal whose VMID bit is set is applied and logged with rejected=0. All masks reset to 0.
- R10: The log holds `LOG_DEPTH` records. A record that arrives while the log holds `LOG_DEPTH` records is dropped, even if a pop happens in the same cycle. The drop sets `log_overflow`, which then stays 1 until reset. The records already held are delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the protection-mode register |
| cfg_protect | input | 1 | New mode: 1 = protected, 0 = fast |
| perm_we | input | 1 | Write a permission mask |
| perm_handle | input | HANDLE_W | Handle whose mask is written |
| perm_mask | input | 2**VMID_W | Write-enable bit per VMID |
| sg_valid | input | 1 | Signal request |
| sg_handle | input | HANDLE_W | Signal target handle |
| sg_vmid | input | VMID_W | Identity of the signalling client |
| sg_value | input | SEQ_W | Sequence value to store |
| sg_err | output | 1 | One-cycle pulse: a signal was refused |
| wt_valid | input | 1 | Wait poll request |
| wt_handle | input | HANDLE_W | Polled handle |
| wt_target | input | SEQ_W | Target sequence |
| wt_rsp_valid | output | 1 | Wait response valid |
| wt_met | output | 1 | Stored value has reached the target |
| wt_value | output | SEQ_W | Stored value seen by the poll |
| q_valid | input | 1 | Host query request |
| q_handle | input | HANDLE_W | Queried handle |
| q_rsp_valid | output | 1 | Query response valid |
| q_value | output | SEQ_W | Current value of the handle |
| q_writer | output | VMID_W | VMID of the last applied writer |
| log_valid | output | 1 | A log record is presented |
| log_ready | input | 1 | Host accepts the presented record |
| log_handle | output | HANDLE_W | Record: handle |
| log_vmid | output | VMID_W | Record: writer VMID |
| log_value | output | SEQ_W | Record: value written or attempted |
| log_rejected | output | 1 | Record: signal was refused |
| log_overflow | output | 1 | Sticky: a record was dropped |

## Verification
The bench polls against a stored value of all ones with a small target. A design that compares as signed numbers would report the wait as unmet. It issues a wait and a signal to the same handle in one cycle. A write-first read would make that wait pass too early. In protected mode it sends a refused signal and then checks three things at the ports: the stored value, the writer, and a log record marked as rejected. A design that applied the signal or skipped its record is caught there. It also overfills the log while the reader stalls. A design that overwrote old records, cleared the overflow flag, or let a held record change would deliver the wrong sequence of records.

// File: rtl/syncobj_pkg.sv
package syncobj_pkg;
  typedef enum logic {
    MODE_FAST    = 1'b0,
    MODE_PROTECT = 1'b1
  } prot_mode_e;
endpackage

// File: rtl/syncobj_perm.sv
module syncobj_perm #(
  parameter int HANDLE_W = 6,
  parameter int VMID_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [HANDLE_W-1:0]        wr_handle,
  input  logic [(1<<VMID_W)-1:0]     wr_mask,
  input  logic [HANDLE_W-1:0]        chk_handle,
  input  logic [VMID_W-1:0]          chk_vmid,
  output logic                       chk_allow
);
  localparam int NUM_OBJ  = 1 << HANDLE_W;
  localparam int NUM_VMID = 1 << VMID_W;

  logic [NUM_VMID-1:0] mask_q [NUM_OBJ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_OBJ; i++) mask_q[i] <= '0;
    end else if (wr_en) begin
      mask_q[wr_handle] <= wr_mask;
    end
  end

  assign chk_allow = mask_q[chk_handle][chk_vmid];
endmodule

// File: rtl/syncobj_store.sv
module syncobj_store #(
  parameter int HANDLE_W = 6,
  parameter int SEQ_W    = 32,
  parameter int VMID_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [HANDLE_W-1:0] waddr,
  input  logic [SEQ_W-1:0]    wdata,
  input  logic [VMID_W-1:0]   wvmid,
  input  logic [HANDLE_W-1:0] a_addr,
  output logic [SEQ_W-1:0]    a_value,
  input  logic [HANDLE_W-1:0] b_addr,
  output logic [SEQ_W-1:0]    b_value,
  output logic [VMID_W-1:0]   b_writer
);
  localparam int NUM_OBJ = 1 << HANDLE_W;

  logic [SEQ_W-1:0]  wait_mem   [NUM_OBJ];
  logic [SEQ_W-1:0]  host_mem   [NUM_OBJ];
  logic [VMID_W-1:0] writer_mem [NUM_OBJ];
  logic [NUM_OBJ-1:0] live_q;

  logic [SEQ_W-1:0]  a_data_q, b_data_q;
  logic [VMID_W-1:0] b_wr_q;
  logic              a_live_q, b_live_q;

  always_ff @(posedge clk) begin
    if (we) wait_mem[waddr] <= wdata;
    a_data_q <= wait_mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (we) begin
      host_mem[waddr]   <= wdata;
      writer_mem[waddr] <= wvmid;
    end
    b_data_q <= host_mem[b_addr];
    b_wr_q   <= writer_mem[b_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      a_live_q <= 1'b0;
      b_live_q <= 1'b0;
    end else begin
      a_live_q <= live_q[a_addr];
      b_live_q <= live_q[b_addr];
      if (we) live_q[waddr] <= 1'b1;
    end
  end

  assign a_value  = a_live_q ? a_data_q : '0;
  assign b_value  = b_live_q ? b_data_q : '0;
  assign b_writer = b_live_q ? b_wr_q   : '0;
endmodule

// File: rtl/syncobj_log_fifo.sv
module syncobj_log_fifo #(
  parameter int REC_W     = 43,
  parameter int LOG_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [REC_W-1:0] push_rec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [REC_W-1:0] out_rec,
  output logic             overflow
);
  localparam int PTR_W = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [REC_W-1:0] mem [LOG_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, do_push, do_pop;

  assign full      = (count == CNT_W'(LOG_DEPTH));
  assign out_valid = (count != '0);
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;
  assign out_rec   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(LOG_DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(LOG_DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      if (push && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/syncobj_table.sv
module syncobj_table
  import syncobj_pkg::*;
#(
  parameter int HANDLE_W  = 6,
  parameter int SEQ_W     = 32,
  parameter int VMID_W    = 4,
  parameter int LOG_DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic                    cfg_protect,
  input  logic                    perm_we,
  input  logic [HANDLE_W-1:0]     perm_handle,
  input  logic [(1<<VMID_W)-1:0]  perm_mask,
  input  logic                    sg_valid,
  input  logic [HANDLE_W-1:0]     sg_handle,
  input  logic [VMID_W-1:0]       sg_vmid,
  input  logic [SEQ_W-1:0]        sg_value,
  output logic                    sg_err,
  input  logic                    wt_valid,
  input  logic [HANDLE_W-1:0]     wt_handle,
  input  logic [SEQ_W-1:0]        wt_target,
  output logic                    wt_rsp_valid,
  output logic                    wt_met,
  output logic [SEQ_W-1:0]        wt_value,
  input  logic                    q_valid,
  input  logic [HANDLE_W-1:0]     q_handle,
  output logic                    q_rsp_valid,
  output logic [SEQ_W-1:0]        q_value,
  output logic [VMID_W-1:0]       q_writer,
  output logic                    log_valid,
  input  logic                    log_ready,
  output logic [HANDLE_W-1:0]     log_handle,
  output logic [VMID_W-1:0]       log_vmid,
  output logic [SEQ_W-1:0]        log_value,
  output logic                    log_rejected,
  output logic                    log_overflow
);
  localparam int REC_W = HANDLE_W + VMID_W + SEQ_W + 1;

  prot_mode_e       prot_q;
  logic             allow, accept;
  logic [SEQ_W-1:0] tgt_q;
  logic [REC_W-1:0] rec_in, rec_out;

  always_ff @(posedge clk) begin
    if (rst) prot_q <= MODE_FAST;
    else if (cfg_we) prot_q <= cfg_protect ? MODE_PROTECT : MODE_FAST;
  end

  syncobj_perm #(.HANDLE_W(HANDLE_W), .VMID_W(VMID_W)) u_perm (
    .clk(clk), .rst(rst),
    .wr_en(perm_we), .wr_handle(perm_handle), .wr_mask(perm_mask),
    .chk_handle(sg_handle), .chk_vmid(sg_vmid), .chk_allow(allow)
  );

  assign accept = (prot_q == MODE_FAST) || allow;

  syncobj_store #(.HANDLE_W(HANDLE_W), .SEQ_W(SEQ_W), .VMID_W(VMID_W)) u_store (
    .clk(clk), .rst(rst),
    .we(sg_valid && accept), .waddr(sg_handle), .wdata(sg_value), .wvmid(sg_vmid),
    .a_addr(wt_handle), .a_value(wt_value),
    .b_addr(q_handle), .b_value(q_value), .b_writer(q_writer)
  );

  assign rec_in = {sg_handle, sg_vmid, sg_value, !accept};

  syncobj_log_fifo #(.REC_W(REC_W), .LOG_DEPTH(LOG_DEPTH)) u_log (
    .clk(clk), .rst(rst),
    .push(sg_valid), .push_rec(rec_in),
    .out_valid(log_valid), .out_ready(log_ready), .out_rec(rec_out),
    .overflow(log_overflow)
  );

  assign {log_handle, log_vmid, log_value, log_rejected} = rec_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      sg_err       <= 1'b0;
      wt_rsp_valid <= 1'b0;
      q_rsp_valid  <= 1'b0;
      tgt_q        <= '0;
    end else begin
      sg_err       <= sg_valid && !accept;
      wt_rsp_valid <= wt_valid;
      q_rsp_valid  <= q_valid;
      if (wt_valid) tgt_q <= wt_target;
    end
  end

  assign wt_met = (wt_value >= tgt_q);
endmodule

// File: rtl/syncobj_table_chk.sv
module syncobj_table_chk #(
  parameter int SEQ_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sg_valid,
  input logic             sg_err,
  input logic             wt_valid,
  input logic             wt_rsp_valid,
  input logic             q_valid,
  input logic             q_rsp_valid,
  input logic             log_valid,
  input logic             log_ready,
  input logic [SEQ_W-1:0] log_value,
  input logic             log_overflow,
  input logic             prot_q
);
  AST_ERR_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (rst) sg_err |-> $past(sg_valid)); // R8
  AST_FAST_NO_ERR: assert property (@(posedge clk) disable iff (rst) sg_err |-> $past(prot_q)); // R7
  AST_ERR_IS_LOGGED: assert property (@(posedge clk) disable iff (rst) sg_err |-> (log_valid || log_overflow)); // R8
  AST_WAIT_RSP: assert property (@(posedge clk) disable iff (rst) wt_valid |=> wt_rsp_valid); // R3
  AST_WAIT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !wt_valid |=> !wt_rsp_valid); // R3
  AST_QUERY_RSP: assert property (@(posedge clk) disable iff (rst) q_valid |=> q_rsp_valid); // R2
  AST_NO_LOG_WITHOUT_SIGNAL: assert property (@(posedge clk) disable iff (rst) (!log_valid && !sg_valid) |=> !log_valid); // R5
  AST_LOG_HELD: assert property (@(posedge clk) disable iff (rst) (log_valid && !log_ready) |=> (log_valid && $stable(log_value))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) log_overflow |=> log_overflow); // R10
endmodule

bind syncobj_table syncobj_table_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst(rst), .sg_valid(sg_valid), .sg_err(sg_err),
  .wt_valid(wt_valid), .wt_rsp_valid(wt_rsp_valid),
  .q_valid(q_valid), .q_rsp_valid(q_rsp_valid),
  .log_valid(log_valid), .log_ready(log_ready), .log_value(log_value),
  .log_overflow(log_overflow), .prot_q(prot_q)
);

// File: tb/tb_syncobj_table.sv
module tb_syncobj_table;
  localparam int HW = 6, SW = 32, VW = 4, LD = 8;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_protect = 0, perm_we = 0;
  logic [HW-1:0] perm_handle = '0;
  logic [(1<<VW)-1:0] perm_mask = '0;
  logic sg_valid = 0; logic [HW-1:0] sg_handle = '0; logic [VW-1:0] sg_vmid = '0; logic [SW-1:0] sg_value = '0;
  logic sg_err;
  logic wt_valid = 0; logic [HW-1:0] wt_handle = '0; logic [SW-1:0] wt_target = '0;
  logic wt_rsp_valid, wt_met; logic [SW-1:0] wt_value;
  logic q_valid = 0; logic [HW-1:0] q_handle = '0;
  logic q_rsp_valid; logic [SW-1:0] q_value; logic [VW-1:0] q_writer;
  logic log_valid, log_ready = 0, log_rejected, log_overflow;
  logic [HW-1:0] log_handle; logic [VW-1:0] log_vmid; logic [SW-1:0] log_value;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  syncobj_table #(.HANDLE_W(HW), .SEQ_W(SW), .VMID_W(VW), .LOG_DEPTH(LD)) dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic signal(input int h, input int v, input logic [31:0] val);
    sg_valid = 1; sg_handle = HW'(h); sg_vmid = VW'(v); sg_value = val;
    step();
    sg_valid = 0;
  endtask

  task automatic query(input int h, input int exp_val, input int exp_wr, input string req);
    q_valid = 1; q_handle = HW'(h);
    step();
    q_valid = 0;
    check({req, " q_rsp_valid"}, 32'(q_rsp_valid), 1);
    check({req, " q_value"}, q_value, exp_val);
    check({req, " q_writer"}, 32'(q_writer), exp_wr);
  endtask

  task automatic poll(input int h, input logic [31:0] tgt, input int exp_met, input string req);
    wt_valid = 1; wt_handle = HW'(h); wt_target = tgt;
    step();
    wt_valid = 0;
    check({req, " wt_rsp_valid"}, 32'(wt_rsp_valid), 1);
    check({req, " wt_met"}, 32'(wt_met), exp_met);
  endtask

  task automatic pop(input int h, input int v, input logic [31:0] val, input int rej, input string req);
    check({req, " log_valid"}, 32'(log_valid), 1);
    check({req, " log_handle"}, 32'(log_handle), h);
    check({req, " log_vmid"}, 32'(log_vmid), v);
    check({req, " log_value"}, log_value, val);
    check({req, " log_rejected"}, 32'(log_rejected), rej);
    log_ready = 1;
    step();
    log_ready = 0;
  endtask

  task automatic set_mode(input logic p);
    cfg_we = 1; cfg_protect = p; step(); cfg_we = 0;
  endtask

  task automatic t_reset();
    check("R1 log_valid", 32'(log_valid), 0);
    check("R1 log_overflow", 32'(log_overflow), 0);
    check("R1 sg_err", 32'(sg_err), 0);
    query(5, 0, 0, "R1");
    poll(5, 1, 0, "R1");
    check("R1 wt_value", wt_value, 0);
    check("R5 no log from wait/query", 32'(log_valid), 0);
  endtask

  task automatic t_signal_query();
    signal(3, 2, 32'h100);
    query(3, 32'h100, 2, "R2");
    pop(3, 2, 32'h100, 0, "R6");
    check("R6 log empty", 32'(log_valid), 0);
  endtask

  task automatic t_wait();
    poll(3, 32'hFF, 1, "R3 below");
    poll(3, 32'h100, 1, "R3 equal");
    poll(3, 32'h101, 0, "R3 above");
    signal(4, 1, 32'hFFFF_FFFF);
    poll(4, 32'h7, 1, "R3 unsigned");
    check("R3 wt_value", wt_value, 32'hFFFF_FFFF);
    pop(4, 1, 32'hFFFF_FFFF, 0, "R6");
    step();
    check("R3 rsp drops", 32'(wt_rsp_valid), 0);
    check("R5 no log after polls", 32'(log_valid), 0);
  endtask

  task automatic t_same_cycle();
    sg_valid = 1; sg_handle = 3; sg_vmid = 2; sg_value = 32'h200;
    wt_valid = 1; wt_handle = 3; wt_target = 32'h200;
    step();
    sg_valid = 0; wt_valid = 0;
    check("R4 wt_met old", 32'(wt_met), 0);
    check("R4 wt_value old", wt_value, 32'h100);
    poll(3, 32'h200, 1, "R4 after");
    pop(3, 2, 32'h200, 0, "R4");
  endtask

  task automatic t_fast();
    signal(7, 9, 32'h33);
    check("R7 sg_err", 32'(sg_err), 0);
    query(7, 32'h33, 9, "R7");
    pop(7, 9, 32'h33, 0, "R7");
  endtask

  task automatic t_protect();
    set_mode(1);
    signal(7, 1, 32'h55);
    check("R8 sg_err pulse", 32'(sg_err), 1);
    step();
    check("R8 sg_err one cycle", 32'(sg_err), 0);
    query(7, 32'h33, 9, "R8 unchanged");
    pop(7, 1, 32'h55, 1, "R8 logged");
    perm_we = 1; perm_handle = 7; perm_mask = 16'h0002;
    step();
    perm_we = 0;
    signal(7, 1, 32'h56);
    check("R9 sg_err", 32'(sg_err), 0);
    query(7, 32'h56, 1, "R9 applied");
    pop(7, 1, 32'h56, 0, "R9 logged");
    signal(7, 9, 32'h57);
    check("R9 other vmid refused", 32'(sg_err), 1);
    query(7, 32'h56, 1, "R9 mask per vmid");
    pop(7, 9, 32'h57, 1, "R9");
    set_mode(0);
    signal(7, 9, 32'h58);
    check("R7 fast again", 32'(sg_err), 0);
    query(7, 32'h58, 9, "R7 fast again");
    pop(7, 9, 32'h58, 0, "R7");
  endtask

  task automatic t_overflow();
    check("R10 empty start", 32'(log_valid), 0);
    for (int i = 0; i < LD; i++) signal(10, 0, 32'hA0 + 32'(i));
    check("R10 no overflow yet", 32'(log_overflow), 0);
    sg_valid = 1; sg_handle = 10; sg_vmid = 0; sg_value = 32'hEE; log_ready = 1;
    step();
    sg_valid = 0; log_ready = 0;
    check("R10 overflow on full push with pop", 32'(log_overflow), 1);
    step();
    check("R6 held while stalled", log_value, 32'hA1);
    for (int i = 1; i < LD; i++) pop(10, 0, 32'hA0 + 32'(i), 0, "R10 order");
    check("R10 dropped record absent", 32'(log_valid), 0);
    check("R10 overflow sticky", 32'(log_overflow), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_signal_query();
    t_wait();
    t_same_cycle();
    t_fast();
    t_protect();
    t_overflow();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule